// File: doc/BRIEF.md
# BT.656 Stream Timing Decoder

This block takes an 8-bit BT.656 byte stream, one byte per clock, already in the system clock domain. It finds the embedded timing reference codes and turns them into horizontal blanking, vertical blanking and field flags. Between a start-of-active-video code and the next code, on lines outside vertical blanking, it sends the active bytes out as a pixel stream qualified by a valid strobe.

Active video in the stream is 4:2:2 luma/chroma. By default the block passes it on as 4:2:2: one output per luma sample, with the chroma sample that belongs to it. When the 4:4:4 mode input is high, the block gives every pixel both chroma components. It builds the missing ones by averaging the neighbouring chroma samples. A scaler further down the chain only accepts 4:2:2, so a high scaler-enable input overrides the mode request. The block reads the effective mode once per line, at the start-of-active-video code.

Top module: `bt656_rx`

## Requirements
- R1: While reset is high, and after it until the first code, hsync, vsync, field, pix_vld, pix_y, pix_c0 and pix_c1 are all 0.
- R2: A code is the bytes 0xFF, 0x00, 0x00, then XY with XY bit 7 = 1. In the cycle after XY, hsync equals XY bit 4, vsync equals XY bit 5 and field equals XY bit 6. XY bits 3:0 are ignored.
- R3: If 0xFF, 0x00, 0x00 is followed by a byte with bit 7 = 0, it is not a code. The flags stay as they were, and inside active video all four bytes come out as pixel data.
- R4: An 0xFF in active video that is not followed by 0x00, 0x00 is pixel data. Detection starts over from the next byte.
- R5: Pixels are produced only from bytes after a code with bit 4 = 0 and bit 5 = 0, up to the next code. Code bytes never appear as pixels. Lines whose start code has bit 5 = 1 produce no pixels. No pixel is lost.
- R6: In 4:2:2 output, active bytes are taken in the order Cb, Y0, Cr, Y1. Each luma byte gives one pixel. For the first luma of a pair, pix_c0 = Cb; for the second, pix_c0 = Cr. pix_c1 = 0 in this mode, and two pixels never come out in consecutive cycles.
- R7: In 4:4:4 output, the first pixel of a pair carries (Y0, Cb, Cr) on (pix_y, pix_c0, pix_c1). The second pixel carries Y1 with each chroma value equal to (this pair's sample + next pair's sample + 1) >> 1.
- R8: In 4:4:4 output, the second pixel of the last complete pair on a line repeats that pair's Cb and Cr.
- R9: The effective mode is mode444 AND NOT scaler_en, latched at each start-of-active-video code. Changing either input during a line does not change that line's format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one stream byte per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | BT.656 stream byte |
| mode444 | input | 1 | Request for 4:4:4 output |
| scaler_en | input | 1 | Downstream scaler active; forces 4:2:2 |
| hsync | output | 1 | Horizontal blanking flag from the last code |
| vsync | output | 1 | Vertical blanking flag from the last code |
| field | output | 1 | Field flag from the last code |
| pix_vld | output | 1 | Pixel strobe |
| pix_y | output | 8 | Luma of the pixel |
| pix_c0 | output | 8 | Cb in 4:4:4; co-sited chroma in 4:2:2 |
| pix_c1 | output | 8 | Cr in 4:4:4; zero in 4:2:2 |

## Verification
The lines are driven with generated chroma and luma values that differ in every pair. This tells the two chroma orders apart, and it shows up any error in the averaging between pairs or in the repeat at the end of the line. One line is sent in vertical blanking to show that it gives no pixels, and the field bit is switched between lines to separate the three flags. Two lines carry bytes that look like codes, 0xFF-0x00-0x00 with a bit-7-clear fourth byte and an 0xFF-0x00 run cut short, to tell real codes from look-alike data. Other lines turn the scaler override on or toggle the mode in mid-line, which shows the mode is latched at the start code and not read live.

// File: rtl/bt656_pkg.sv
package bt656_pkg;
    localparam int BW = 8;
    localparam int PREAMBLE_LEN = 3;

    typedef logic [BW-1:0] byte_t;

    localparam byte_t ALL_ONES = {BW{1'b1}};
    localparam byte_t ALL_ZERO = {BW{1'b0}};

    typedef enum logic [1:0] {
        TRS_IDLE,
        TRS_ONES,
        TRS_Z1,
        TRS_Z2
    } trs_state_e;

    typedef enum logic [1:0] {
        PH_CB,
        PH_Y0,
        PH_CR,
        PH_Y1
    } phase_e;

    // flags carried by the status byte of a code
    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } sync_t;

    typedef struct packed {
        logic  vld;
        byte_t b;
    } tbyte_t;

    typedef struct packed {
        byte_t y;
        byte_t c0;
        byte_t c1;
    } pix_t;

    function automatic byte_t avg_up(input byte_t a, input byte_t b);
        logic [BW:0] s;
        s = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, 1'b1};
        return s[BW:1];
    endfunction
endpackage

// File: rtl/bt656_trs_detect.sv
module bt656_trs_detect
    import bt656_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t din,
    output logic  code_hit,
    output sync_t flags
);
    trs_state_e st_q, st_d;

    always_comb begin
        code_hit = 1'b0;
        flags    = '{f: din[6], v: din[5], h: din[4]};
        st_d     = TRS_IDLE;
        unique case (st_q)
            TRS_IDLE: st_d = (din == ALL_ONES) ? TRS_ONES : TRS_IDLE;
            TRS_ONES: st_d = (din == ALL_ZERO) ? TRS_Z1 :
                             (din == ALL_ONES) ? TRS_ONES : TRS_IDLE;
            TRS_Z1:   st_d = (din == ALL_ZERO) ? TRS_Z2 :
                             (din == ALL_ONES) ? TRS_ONES : TRS_IDLE;
            TRS_Z2: begin
                code_hit = din[BW-1];
                st_d     = (din == ALL_ONES) ? TRS_ONES : TRS_IDLE;
            end
            default: st_d = TRS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TRS_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/bt656_byte_lag.sv
module bt656_byte_lag
    import bt656_pkg::*;
#(
    parameter int LAG = PREAMBLE_LEN
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   kill,
    input  tbyte_t in_b,
    output tbyte_t out_b
);
    tbyte_t stg_q [LAG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LAG; i++) begin
            if (rst || kill)  stg_q[i] <= '0;
            else if (i == 0)  stg_q[i] <= in_b;
            else              stg_q[i] <= stg_q[i-1];
        end
    end

    // the oldest byte is dropped when it turns out to be part of a code
    always_comb begin
        out_b     = stg_q[LAG-1];
        out_b.vld = stg_q[LAG-1].vld && !kill;
    end
endmodule

// File: rtl/bt656_chroma_fmt.sv
module bt656_chroma_fmt
    import bt656_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  byte_t in_b,
    input  logic  flush,
    input  logic  m444,
    output logic  out_vld,
    output pix_t  out_pix
);
    phase_e ph_q;
    byte_t  cb_q, y0_q, cr_q;
    logic   pend_q;
    pix_t   pend_pix_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_CB;
            cb_q       <= '0;
            y0_q       <= '0;
            cr_q       <= '0;
            pend_q     <= 1'b0;
            pend_pix_q <= '0;
            out_vld    <= 1'b0;
            out_pix    <= '0;
        end else begin
            out_vld <= 1'b0;
            if (flush) begin
                ph_q   <= PH_CB;
                pend_q <= 1'b0;
                if (pend_q) begin
                    out_vld <= 1'b1;
                    out_pix <= pend_pix_q;
                end
            end else if (in_vld) begin
                ph_q <= phase_e'(ph_q + 2'd1);
                unique case (ph_q)
                    PH_CB: cb_q <= in_b;
                    PH_Y0: begin
                        y0_q <= in_b;
                        if (!m444) begin
                            out_vld <= 1'b1;
                            out_pix <= '{y: in_b, c0: cb_q, c1: ALL_ZERO};
                        end
                    end
                    PH_CR: begin
                        cr_q <= in_b;
                        if (m444 && pend_q) begin
                            out_vld <= 1'b1;
                            out_pix <= '{y:  pend_pix_q.y,
                                         c0: avg_up(pend_pix_q.c0, cb_q),
                                         c1: avg_up(pend_pix_q.c1, in_b)};
                            pend_q  <= 1'b0;
                        end
                    end
                    PH_Y1: begin
                        out_vld <= 1'b1;
                        if (!m444) begin
                            out_pix <= '{y: in_b, c0: cr_q, c1: ALL_ZERO};
                        end else begin
                            out_pix    <= '{y: y0_q, c0: cb_q, c1: cr_q};
                            pend_q     <= 1'b1;
                            pend_pix_q <= '{y: in_b, c0: cb_q, c1: cr_q};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bt656_rx.sv
module bt656_rx
    import bt656_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  din,
    input  logic        mode444,
    input  logic        scaler_en,
    output logic        hsync,
    output logic        vsync,
    output logic        field,
    output logic        pix_vld,
    output logic [7:0]  pix_y,
    output logic [7:0]  pix_c0,
    output logic [7:0]  pix_c1
);
    logic   code_hit;
    sync_t  flags;
    logic   act_q;
    logic   fmt444_q;
    tbyte_t lag_in, lag_out;
    pix_t   pix;

    bt656_trs_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .code_hit (code_hit),
        .flags    (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync    <= 1'b0;
            vsync    <= 1'b0;
            field    <= 1'b0;
            act_q    <= 1'b0;
            fmt444_q <= 1'b0;
        end else if (code_hit) begin
            hsync <= flags.h;
            vsync <= flags.v;
            field <= flags.f;
            act_q <= !flags.h && !flags.v;
            if (!flags.h) fmt444_q <= mode444 && !scaler_en;
        end
    end

    assign lag_in = '{vld: act_q && !code_hit, b: din};

    bt656_byte_lag #(.LAG(PREAMBLE_LEN)) u_lag (
        .clk   (clk),
        .rst   (rst),
        .kill  (code_hit),
        .in_b  (lag_in),
        .out_b (lag_out)
    );

    bt656_chroma_fmt u_fmt (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (lag_out.vld),
        .in_b    (lag_out.b),
        .flush   (code_hit),
        .m444    (fmt444_q),
        .out_vld (pix_vld),
        .out_pix (pix)
    );

    assign pix_y  = pix.y;
    assign pix_c0 = pix.c0;
    assign pix_c1 = pix.c1;
endmodule

// File: rtl/bt656_rx_chk.sv
module bt656_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] din,
    input logic       scaler_en,
    input logic       hsync,
    input logic       vsync,
    input logic       field,
    input logic       pix_vld,
    input logic [7:0] pix_c1,
    input logic       fmt444_q,
    input logic       code_hit
);
    // R2
    flags_follow_code_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(din, 3) == 8'hFF && $past(din, 2) == 8'h00 && $past(din, 1) == 8'h00 && din[7])
        |=> (hsync == $past(din[4]) && vsync == $past(din[5]) && field == $past(din[6])));

    // R3
    fake_code_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(din, 3) == 8'hFF && $past(din, 2) == 8'h00 && $past(din, 1) == 8'h00 && !din[7])
        |=> ($stable(hsync) && $stable(vsync) && $stable(field)));

    // R6
    c1_zero_422_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && !fmt444_q) |-> (pix_c1 == 8'h00));

    // R6
    no_burst_422_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && !fmt444_q) |=> !pix_vld);

    // R9
    scaler_forces_422_chk: assert property (@(posedge clk) disable iff (rst)
        (code_hit && !din[4] && scaler_en) |=> !fmt444_q);
endmodule

bind bt656_rx bt656_rx_chk chk_i (.*);

// File: tb/bt656_rx_tb_top.sv
module bt656_rx_tb_top;
    import bt656_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic       mode444, scaler_en;
    logic       hsync, vsync, field, pix_vld;
    logic [7:0] pix_y, pix_c0, pix_c1;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    pix_t  exp_q [$];
    string req_q [$];
    byte_t lcb [16], ly0 [16], lcr [16], ly1 [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bt656_rx dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, want);
        end
    endtask

    // monitor: compares every produced pixel against the scoreboard
    always @(negedge clk) begin
        if (!rst && pix_vld) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R5 unexpected pixel: got y=%0h c0=%0h c1=%0h expected none",
                         pix_y, pix_c0, pix_c1);
            end else begin
                pix_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, "pix_y", pix_y, e.y);
                check(r, "pix_c0", pix_c0, e.c0);
                check(r, "pix_c1", pix_c1, e.c1);
            end
        end
    end

    task automatic send_byte(input byte_t b);
        @(negedge clk);
        din = b;
    endtask

    task automatic send_code(input logic f, input logic v, input logic h);
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h});
        @(posedge clk);
        #1;
        check("R2", "hsync", hsync, h);
        check("R2", "vsync", vsync, v);
        check("R2", "field", field, f);
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) send_byte((i % 2) ? 8'h10 : 8'h80);
    endtask

    function automatic byte_t gen(input int seed, input int k, input int j);
        return 8'h10 + byte_t'((seed * 53 + k * 37 + j * 11) % 224);
    endfunction

    task automatic fill(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            lcb[k] = gen(seed, k, 0);
            ly0[k] = gen(seed, k, 1);
            lcr[k] = gen(seed, k, 2);
            ly1[k] = gen(seed, k, 3);
        end
    endtask

    task automatic expect_line(input int n, input logic m, input string req);
        for (int k = 0; k < n; k++) begin
            if (!m) begin
                exp_q.push_back('{y: ly0[k], c0: lcb[k], c1: 8'h00}); req_q.push_back(req);
                exp_q.push_back('{y: ly1[k], c0: lcr[k], c1: 8'h00}); req_q.push_back(req);
            end else begin
                exp_q.push_back('{y: ly0[k], c0: lcb[k], c1: lcr[k]}); req_q.push_back(req);
                if (k < n - 1) begin
                    exp_q.push_back('{y: ly1[k],
                                      c0: byte_t'((9'(lcb[k]) + 9'(lcb[k+1]) + 9'd1) >> 1),
                                      c1: byte_t'((9'(lcr[k]) + 9'(lcr[k+1]) + 9'd1) >> 1)});
                    req_q.push_back(req);
                end else begin
                    // R8: end of line repeats the last chroma
                    exp_q.push_back('{y: ly1[k], c0: lcb[k], c1: lcr[k]});
                    req_q.push_back("R8");
                end
            end
        end
    endtask

    task automatic send_pairs(input int n, input bit flip);
        for (int k = 0; k < n; k++) begin
            send_byte(lcb[k]);
            send_byte(ly0[k]);
            send_byte(lcr[k]);
            send_byte(ly1[k]);
            if (flip && k == 1) begin
                mode444   = ~mode444;
                scaler_en = ~scaler_en;
            end
        end
    endtask

    task automatic run_line(input int n, input logic m, input logic scal, input logic f,
                            input string req, input bit flip);
        mode444   = m;
        scaler_en = scal;
        expect_line(n, m & ~scal, req);
        send_code(f, 1'b0, 1'b0);
        send_pairs(n, flip);
        send_code(f, 1'b0, 1'b1);
        blank(6);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        din       = 8'h00;
        mode444   = 1'b0;
        scaler_en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "hsync", hsync, 0);
        check("R1", "pix_vld", pix_vld, 0);
        rst = 1'b0;
        blank(8);
        // R1: still idle after reset, no code seen yet
        check("R1", "vsync", vsync, 0);
        check("R1", "field", field, 0);
        check("R1", "pix_vld", pix_vld, 0);
        check("R1", "pix_y", pix_y, 0);
        check("R1", "pix_c0/c1", {pix_c0, pix_c1}, 0);

        // R5: a line in vertical blanking yields no pixels
        send_code(1'b0, 1'b1, 1'b1);
        blank(4);
        send_code(1'b0, 1'b1, 1'b0);
        fill(4, 1);
        send_pairs(4, 0);
        send_code(1'b0, 1'b1, 1'b1);
        blank(6);

        // R6: plain 4:2:2
        fill(6, 2);
        run_line(6, 1'b0, 1'b0, 1'b0, "R6", 0);

        // R7: 4:4:4 interpolation, field 1
        fill(6, 3);
        run_line(6, 1'b1, 1'b0, 1'b1, "R7", 0);

        // R9: scaler override forces 4:2:2
        fill(5, 4);
        run_line(5, 1'b1, 1'b1, 1'b0, "R9", 0);

        // R9: mid-line mode change has no effect on the line
        fill(6, 5);
        run_line(6, 1'b1, 1'b0, 1'b0, "R9", 1);
        fill(4, 6);
        run_line(4, 1'b0, 1'b1, 1'b1, "R9", 1);

        // R3: FF 00 00 followed by a bit-7-clear byte is data
        fill(4, 7);
        lcb[1] = 8'hFF; ly0[1] = 8'h00; lcr[1] = 8'h00; ly1[1] = 8'h55;
        run_line(4, 1'b0, 1'b0, 1'b0, "R3", 0);

        // R4: broken FF 00 run inside active video is data (4:4:4 averaging too)
        fill(4, 8);
        lcb[2] = 8'hFF; ly0[2] = 8'h00; lcr[2] = 8'h55; ly1[2] = 8'h00;
        run_line(4, 1'b1, 1'b0, 1'b0, "R4", 0);

        blank(12);
        // R5: every expected pixel arrived
        check("R5", "pending pixels", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule